// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. It holds the integrator in its cleared state while idle. On a start request it connects the integrator to the unknown voltage for a fixed interval. That interval is one full cycle of an internal binary counter. The counter's carry-out moves the integrator input over to the negative reference and returns the counter to zero. The same counter then measures how long the integrator takes to discharge.

The discharge ends when the external zero-crossing comparator reports that the integrator output has crossed zero. The comparator signal is asynchronous, so it passes through two synchronizing flops before the sequencer acts on it. The count held at the stop is the conversion result. That result scales with the input voltage as Vin = Vref x (discharge count / full run-up count).

If the comparator never trips within a full discharge count, the sequencer stops anyway. In that case it reports a saturated result and raises an overrange flag.

Top module: `dsadc_seq`

## Requirements
- R1: While reset is asserted and directly after it, the block is idle: `int_clear_o` is 1, both select outputs are 0, and `done_o`, `ovr_o` and `result_o` are all 0.
- R2: In idle, `int_clear_o` is 1 and neither select output is active. A start sampled high in idle makes `sel_vin_o` go high on the next clock, and `int_clear_o` falls at that same clock.
- R3: `sel_vin_o` stays high for exactly 2^CNT_W clocks. This holds regardless of the comparator input.
- R4: The counter's carry-out at the end of run-up makes `sel_vref_o` go high on the very next clock, with no idle cycle in between. The counter restarts from 0 in that clock.
- R5: The comparator goes through a two-flop synchronizer. If the comparator input is first seen high in run-down clock a (with clock 0 being the first clock of run-down), the result is a+2 and `sel_vref_o` stays high for a+3 clocks.
- R6: If the comparator is already high when run-down begins, the result is 0 and `sel_vref_o` stays high for 1 clock. A comparator that is high during run-up has no effect on run-up.
- R7: If the synchronized comparator has not tripped by the time the counter reaches its maximum in run-down, the conversion ends. The result is all ones, `ovr_o` is 1, and `sel_vref_o` has been high for 2^CNT_W clocks. A trip seen in that same last clock takes priority, giving a result of all ones with `ovr_o` 0.
- R8: `done_o` is a single-clock pulse that marks the end of a conversion, and the block is idle on the following clock. `result_o` and `ovr_o` change only in the clock in which `done_o` is high.
- R9: A start request raised during run-up or run-down is ignored. The conversion in progress keeps its timing and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, acted on only when idle |
| zc_i | input | 1 | Asynchronous zero-crossing comparator output, high once the integrator has crossed zero |
| sel_vin_o | output | 1 | Connects the integrator to the unknown voltage (run-up) |
| sel_vref_o | output | 1 | Connects the integrator to the negative reference (run-down) |
| int_clear_o | output | 1 | Holds the integrator capacitor discharged (idle) |
| result_o | output | CNT_W | Run-down count of the last conversion |
| ovr_o | output | 1 | Last conversion saturated without a zero crossing |
| done_o | output | 1 | One-clock end-of-conversion pulse |

## Verification
The hardest case to reach is the last clock of run-down. There, the counter's carry and the synchronized comparator trip arrive together, and the trip has to win over the overrange path. The bench models the integrator as an integer: it raises the comparator a chosen number of clocks into run-down. It then places the trip at the one offset, 2^CNT_W-3, whose two-flop delay lands exactly on the counter's maximum, and at the next offset, which must overflow. A comparator held high from before start covers the zero-result case, and a start pulse issued mid-conversion checks that a busy conversion ignores new requests.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUNUP = 2'd1,
    ST_RUNDN = 2'd2,
    ST_DONE  = 2'd3
  } dsadc_state_e;

  // Next counter value; wraps to zero after the all-ones value.
  function automatic logic [31:0] cnt_step(input logic [31:0] cur, input int unsigned width);
    logic [31:0] mask;
    mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    return (cur + 32'd1) & mask;
  endfunction

  // True when the counter sits at its terminal (all-ones) value.
  function automatic logic cnt_full(input logic [31:0] cur, input int unsigned width);
    logic [31:0] mask;
    mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    return (cur & mask) == mask;
  endfunction
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dsadc_counter.sv
module dsadc_counter
  import dsadc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             carry_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= CNT_W'(cnt_step(32'(cnt_q), CNT_W));
  end

  assign cnt_o   = cnt_q;
  assign carry_o = en_i && cnt_full(32'(cnt_q), CNT_W);
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             zc_i,
  output logic             sel_vin_o,
  output logic             sel_vref_o,
  output logic             int_clear_o,
  output logic [CNT_W-1:0] result_o,
  output logic             ovr_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  dsadc_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt;
  logic             carry;
  logic             zc_s;
  logic             cnt_clr, cnt_en;
  logic             trip_ev;
  logic             ovr_ev;
  logic             phase_sw_ev;
  logic [CNT_W-1:0] res_q;
  logic             ovr_q;

  dsadc_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (zc_i),
    .q_o   (zc_s)
  );

  dsadc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (cnt_clr),
    .en_i    (cnt_en),
    .cnt_o   (cnt),
    .carry_o (carry)
  );

  assign cnt_en      = (state_q == ST_RUNUP) || (state_q == ST_RUNDN);
  assign cnt_clr     = (state_q == ST_IDLE)  || (state_q == ST_DONE);
  assign phase_sw_ev = (state_q == ST_RUNUP) && carry;
  assign trip_ev     = (state_q == ST_RUNDN) && zc_s;
  assign ovr_ev      = (state_q == ST_RUNDN) && !zc_s && carry;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_RUNUP;
      ST_RUNUP: if (phase_sw_ev) state_d = ST_RUNDN;
      ST_RUNDN: if (trip_ev || ovr_ev) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      res_q   <= '0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (trip_ev) begin
        res_q <= cnt;
        ovr_q <= 1'b0;
      end else if (ovr_ev) begin
        res_q <= CNT_MAX;
        ovr_q <= 1'b1;
      end
    end
  end

  assign sel_vin_o   = (state_q == ST_RUNUP);
  assign sel_vref_o  = (state_q == ST_RUNDN);
  assign int_clear_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign result_o    = res_q;
  assign ovr_o       = ovr_q;
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             sel_vin_o,
  input logic             sel_vref_o,
  input logic             int_clear_o,
  input logic             done_o,
  input logic             ovr_o,
  input logic [CNT_W-1:0] result_o,
  input logic [CNT_W-1:0] cnt,
  input logic             phase_sw_ev,
  input logic             zc_s
);
  p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_vin_o, sel_vref_o, int_clear_o, done_o}));

  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clear_o && start_i) |=> sel_vin_o);

  p_switch_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_sw_ev |=> (sel_vref_o && cnt == '0));

  p_runup_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_vin_o) |-> sel_vref_o);

  p_trip_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vref_o && zc_s) |=> (done_o && result_o == $past(cnt) && !ovr_o));

  p_sat_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ovr_o) |-> result_o == '1);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> int_clear_o);

  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(ovr_o)));

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vref_o && start_i && !zc_s) |=> !sel_vin_o);
endmodule

bind dsadc_seq dsadc_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .sel_vin_o   (sel_vin_o),
  .sel_vref_o  (sel_vref_o),
  .int_clear_o (int_clear_o),
  .done_o      (done_o),
  .ovr_o       (ovr_o),
  .result_o    (result_o),
  .cnt         (cnt),
  .phase_sw_ev (phase_sw_ev),
  .zc_s        (zc_s)
);

// File: tb/dsadc_seq_bench.sv
module dsadc_seq_bench;
  localparam int W    = 8;
  localparam int FULL = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         zc_i = 1'b0;
  logic         sel_vin_o, sel_vref_o, int_clear_o, ovr_o, done_o;
  logic [W-1:0] result_o;

  int checks = 0;
  int errors = 0;

  // measurements of the last conversion
  int           m_up, m_dn;
  logic [W-1:0] m_res;
  logic         m_ovr, m_done_after;

  always #5 clk = ~clk;

  dsadc_seq #(.CNT_W(W)) u_dsadc_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .zc_i(zc_i),
    .sel_vin_o(sel_vin_o), .sel_vref_o(sel_vref_o), .int_clear_o(int_clear_o),
    .result_o(result_o), .ovr_o(ovr_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // trip_at >= 0 : comparator raised in that run-down clock
  // trip_at == -1: never raised (overrange)
  // trip_at == -2: held high from before start
  // busy_start   : pulse start during run-up and run-down
  task automatic convert(input int trip_at, input bit busy_start);
    int guard;
    if (trip_at == -2) zc_i = 1'b1;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    m_up = 0; guard = 0;
    while (sel_vin_o && guard < 4 * FULL) begin
      if (busy_start && m_up == 10) start_i = 1'b1;
      else start_i = 1'b0;
      m_up++; guard++;
      @(negedge clk);
    end
    start_i = 1'b0;
    m_dn = 0; guard = 0;
    while (sel_vref_o && guard < 4 * FULL) begin
      if (trip_at >= 0 && m_dn == trip_at) zc_i = 1'b1;
      if (busy_start && m_dn == 3) start_i = 1'b1;
      else start_i = 1'b0;
      m_dn++; guard++;
      @(negedge clk);
    end
    start_i = 1'b0;
    m_res = result_o;
    m_ovr = ovr_o;
    chk("R8", "done pulse high", int'(done_o), 1);
    @(negedge clk);
    m_done_after = done_o;
    chk("R8", "done pulse one clock", int'(m_done_after), 0);
    chk("R8", "idle after done", int'(int_clear_o), 1);
    chk("R8", "result held", int'(result_o), int'(m_res));
    zc_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "int_clear in reset", int'(int_clear_o), 1);
    chk("R1", "selects in reset", int'({sel_vin_o, sel_vref_o}), 0);
    chk("R1", "done/ovr in reset", int'({done_o, ovr_o}), 0);
    chk("R1", "result in reset", int'(result_o), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "idle after reset", int'(int_clear_o), 1);
    chk("R2", "no select in idle", int'({sel_vin_o, sel_vref_o}), 0);
  endtask

  task automatic t_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk("R2", "runup after start", int'(sel_vin_o), 1);
    chk("R2", "clear dropped", int'(int_clear_o), 0);
    // let this conversion run to overrange and settle
    while (!done_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_trip(input int a);
    convert(a, 1'b0);
    chk("R3", "runup length", m_up, FULL);
    chk("R4", "rundown follows runup", int'(m_dn > 0), 1);
    chk("R5", "result", int'(m_res), a + 2);
    chk("R5", "rundown length", m_dn, a + 3);
    chk("R5", "no overrange", int'(m_ovr), 0);
  endtask

  task automatic t_early();
    convert(-2, 1'b0);
    chk("R6", "runup length with comparator high", m_up, FULL);
    chk("R6", "result zero", int'(m_res), 0);
    chk("R6", "rundown one clock", m_dn, 1);
  endtask

  task automatic t_over();
    convert(-1, 1'b0);
    chk("R7", "saturated result", int'(m_res), FULL - 1);
    chk("R7", "overrange flag", int'(m_ovr), 1);
    chk("R7", "rundown full length", m_dn, FULL);
  endtask

  task automatic t_edge();
    convert(FULL - 3, 1'b0);
    chk("R7", "trip at last clock result", int'(m_res), FULL - 1);
    chk("R7", "trip at last clock no ovr", int'(m_ovr), 0);
    convert(FULL - 2, 1'b0);
    chk("R7", "trip too late ovr", int'(m_ovr), 1);
    chk("R7", "trip too late length", m_dn, FULL);
  endtask

  task automatic t_busy();
    convert(20, 1'b1);
    chk("R9", "runup length with busy start", m_up, FULL);
    chk("R9", "result with busy start", int'(m_res), 22);
    chk("R9", "stays idle after", int'(sel_vin_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_start();
    t_trip(0);
    t_trip(7);
    t_trip(100);
    t_over();
    chk("R8", "ovr cleared by normal conversion pre", int'(ovr_o), 1);
    t_trip(5);
    chk("R8", "ovr cleared by normal conversion", int'(ovr_o), 0);
    t_early();
    t_edge();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule